// File: doc/BRIEF.md
# Round-Robin Multi-Size Translation Buffer

This block is a fully associative address translation cache. Each of its entries holds one virtual-to-physical page mapping together with an attribute field. Every entry decides on its own whether its mapping covers a 4 KB small page, a 64 KB large page or a 1 MB segment. A lookup presents a full virtual address. One clock later the block returns the physical address and the stored attributes of the matching entry, or it reports a miss.

Refills are written by a table-walk agent outside the block. The agent supplies the virtual page number, the physical frame number, a size code and the attributes. The block picks the entry to overwrite with a round-robin pointer. A single invalidate-all input empties the whole buffer. The block is fully parameterised, so separate instances can serve the instruction side and the data side. Permission checking is left to the consumer, which receives the attributes unchanged.

Top module: `rr_tlb`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_valid` and `res_hit` are low. Reset empties every entry and sets the replacement pointer to entry 0.
- R2: Size code 0 selects a small page. The entry matches when virtual address bits [31:12] equal the stored page number, and the physical address is the stored frame in bits [31:12] with lookup bits [11:0] below it.
- R3: Size code 1 selects a large page. The entry matches on virtual address bits [31:16], and physical address bits [15:0] are taken from the lookup address.
- R4: Size code 2 selects a segment. The entry matches on virtual address bits [31:20], and physical address bits [19:0] are taken from the lookup address. Code 3 is treated as a small page.
- R5: A request with `lk_valid` high gives `res_valid` high exactly one cycle later. A cycle without a request gives `res_valid` low one cycle later.
- R6: On a hit, `res_attr` carries the attribute value that was written with the matching entry.
- R7: When no valid entry matches the lookup address, `res_hit` is low. `res_hit` is never high while `res_valid` is low.
- R8: Each accepted refill writes the entry under the pointer and then advances the pointer by one, wrapping from ENTRIES-1 to 0. The refill that follows ENTRIES refills after reset therefore evicts the first mapping.
- R9: One cycle of `inv_all` empties every entry. A lookup issued on the next cycle misses.
- R10: A refill presented in the same cycle as `inv_all` is discarded, and the pointer does not move.
- R11: A lookup issued in the same cycle as a refill sees the contents from before that refill.
- R12: The bits of `rf_vpn` and `rf_pfn` that lie inside the page offset of the chosen size have no effect on matching or on the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | VA_W | Virtual address to translate |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | VA_W-SMALL_SHIFT | Virtual page number of the new mapping, in 4 KB units |
| rf_pfn | input | PA_W-SMALL_SHIFT | Physical frame number of the new mapping, in 4 KB units |
| rf_size | input | 2 | Page size code: 0 small, 1 large, 2 segment |
| rf_attr | input | ATTR_W | Attributes stored with the mapping |
| inv_all | input | 1 | Empty every entry |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | The lookup found a mapping |
| res_pa | output | PA_W | Translated physical address, meaningful on a hit |
| res_attr | output | ATTR_W | Attributes of the hit entry, meaningful on a hit |

## Verification
The bench uses the default parameters: 32 entries, 32-bit virtual and physical addresses, 8-bit attributes, and offset widths of 12, 16 and 20 bits for the three sizes. With a depth of 32, filling the whole buffer and wrapping the pointer takes only a few dozen cycles, so eviction order can be checked directly at the ports. Because the three offset widths differ, page-number bits that lie in the offset of a larger page show whether the size-dependent masks are applied to both the compare and the address merge.

// File: rtl/rr_tlb_pkg.sv
package rr_tlb_pkg;
  typedef enum logic [1:0] {
    PG_SMALL = 2'd0,
    PG_LARGE = 2'd1,
    PG_SEG   = 2'd2,
    PG_RSVD  = 2'd3
  } pg_size_e;
endpackage

// File: rtl/rr_tlb_ptr.sv
module rr_tlb_ptr #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  // R8: every accepted refill moves the pointer
  a_r8_ptr_moves: assert property (@(posedge clk) disable iff (rst)
    adv |=> ptr != $past(ptr));
  // R8: no refill, no movement
  a_r8_ptr_holds: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/rr_tlb_store.sv
module rr_tlb_store
  import rr_tlb_pkg::*;
#(
  parameter int ENTRIES     = 32,
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 20,
  parameter int ATTR_W      = 8,
  parameter int LG_BITS     = 4,
  parameter int SG_BITS     = 8,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [VPN_W-1:0]                 wr_vpn,
  input  logic [PFN_W-1:0]                 wr_pfn,
  input  logic [1:0]                       wr_size,
  input  logic [ATTR_W-1:0]                wr_attr,
  input  logic                             inv_all,
  input  logic [VPN_W-1:0]                 lk_vpn,
  output logic [ENTRIES-1:0]               hit_vec,
  output logic [ENTRIES-1:0][PFN_W-1:0]    pfn_all,
  output logic [ENTRIES-1:0][1:0]          size_all,
  output logic [ENTRIES-1:0][ATTR_W-1:0]   attr_all
);
  localparam logic [VPN_W-1:0] MASK_LG = {VPN_W{1'b1}} << LG_BITS;
  localparam logic [VPN_W-1:0] MASK_SG = {VPN_W{1'b1}} << SG_BITS;

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // payload carries no reset, written like a RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
      size_q[wr_idx] <= wr_size;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] cmp_mask;
    always_comb begin
      case (pg_size_e'(size_q[g]))
        PG_LARGE: cmp_mask = MASK_LG;
        PG_SEG:   cmp_mask = MASK_SG;
        default:  cmp_mask = {VPN_W{1'b1}};
      endcase
      hit_vec[g] = valid_q[g] && ((lk_vpn & cmp_mask) == (tag_q[g] & cmp_mask));
    end
    assign pfn_all[g]  = pfn_q[g];
    assign size_all[g] = size_q[g];
    assign attr_all[g] = attr_q[g];
  end

  // R7: correct software never leaves overlapping mappings
  a_r7_one_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/rr_tlb_sel.sv
module rr_tlb_sel
  import rr_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ATTR_W  = 8,
  parameter int LG_BITS = 4,
  parameter int SG_BITS = 8
) (
  input  logic [ENTRIES-1:0]             hit_vec,
  input  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_all,
  input  logic [ENTRIES-1:0][1:0]        size_all,
  input  logic [ENTRIES-1:0][ATTR_W-1:0] attr_all,
  input  logic [VPN_W-1:0]               lk_vpn,
  output logic                           any_hit,
  output logic [PFN_W-1:0]               out_pfn,
  output logic [ATTR_W-1:0]              out_attr
);
  localparam logic [PFN_W-1:0] PMASK_LG = {PFN_W{1'b1}} << LG_BITS;
  localparam logic [PFN_W-1:0] PMASK_SG = {PFN_W{1'b1}} << SG_BITS;

  logic [PFN_W-1:0]  sel_pfn;
  logic [1:0]        sel_size;
  logic [PFN_W-1:0]  keep_mask;
  logic [PFN_W-1:0]  va_part;

  // AND-OR select of the raw fields, merge done once afterwards
  always_comb begin
    sel_pfn  = '0;
    sel_size = '0;
    out_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_pfn  |= {PFN_W{hit_vec[i]}}  & pfn_all[i];
      sel_size |= {2{hit_vec[i]}}      & size_all[i];
      out_attr |= {ATTR_W{hit_vec[i]}} & attr_all[i];
    end
  end

  always_comb begin
    case (pg_size_e'(sel_size))
      PG_LARGE: keep_mask = PMASK_LG;
      PG_SEG:   keep_mask = PMASK_SG;
      default:  keep_mask = {PFN_W{1'b1}};
    endcase
    va_part = PFN_W'(lk_vpn[SG_BITS-1:0]);
    out_pfn = (sel_pfn & keep_mask) | (va_part & ~keep_mask);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/rr_tlb.sv
module rr_tlb #(
  parameter int ENTRIES     = 32,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int ATTR_W      = 8,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 16,
  parameter int SEG_SHIFT   = 20,
  localparam int VPN_W      = VA_W - SMALL_SHIFT,
  localparam int PFN_W      = PA_W - SMALL_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [1:0]        rf_size,
  input  logic [ATTR_W-1:0] rf_attr,
  input  logic              inv_all,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PA_W-1:0]   res_pa,
  output logic [ATTR_W-1:0] res_attr
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int LG_BITS = LARGE_SHIFT - SMALL_SHIFT;
  localparam int SG_BITS = SEG_SHIFT - SMALL_SHIFT;

  logic                           wr_go;
  logic [IDX_W-1:0]               victim;
  logic [VPN_W-1:0]               lk_vpn;
  logic [ENTRIES-1:0]             hit_vec;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_all;
  logic [ENTRIES-1:0][1:0]        size_all;
  logic [ENTRIES-1:0][ATTR_W-1:0] attr_all;
  logic                           sel_hit;
  logic [PFN_W-1:0]               sel_pfn;
  logic [ATTR_W-1:0]              sel_attr;

  assign wr_go  = rf_valid && !inv_all;
  assign lk_vpn = lk_va[VA_W-1:SMALL_SHIFT];

  rr_tlb_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk (clk),
    .rst (rst),
    .adv (wr_go),
    .ptr (victim)
  );

  rr_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W),
    .LG_BITS(LG_BITS), .SG_BITS(SG_BITS)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_go),
    .wr_idx   (victim),
    .wr_vpn   (rf_vpn),
    .wr_pfn   (rf_pfn),
    .wr_size  (rf_size),
    .wr_attr  (rf_attr),
    .inv_all  (inv_all),
    .lk_vpn   (lk_vpn),
    .hit_vec  (hit_vec),
    .pfn_all  (pfn_all),
    .size_all (size_all),
    .attr_all (attr_all)
  );

  rr_tlb_sel #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W),
    .LG_BITS(LG_BITS), .SG_BITS(SG_BITS)
  ) u_sel (
    .hit_vec  (hit_vec),
    .pfn_all  (pfn_all),
    .size_all (size_all),
    .attr_all (attr_all),
    .lk_vpn   (lk_vpn),
    .any_hit  (sel_hit),
    .out_pfn  (sel_pfn),
    .out_attr (sel_attr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_pa    <= '0;
      res_attr  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && sel_hit;
      if (lk_valid) begin
        res_pa   <= {sel_pfn, lk_va[SMALL_SHIFT-1:0]};
        res_attr <= sel_attr;
      end
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> res_valid == $past(lk_valid));
  a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
  a_r9_inv_clears: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !sel_hit);
  a_r10_inv_blocks_fill: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> $stable(victim));
endmodule

// File: tb/rr_tlb_tb_top.sv
module rr_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rf_valid = 1'b0;
  logic [19:0] rf_vpn = '0;
  logic [19:0] rf_pfn = '0;
  logic [1:0]  rf_size = '0;
  logic [7:0]  rf_attr = '0;
  logic        inv_all = 1'b0;
  logic        res_valid;
  logic        res_hit;
  logic [31:0] res_pa;
  logic [7:0]  res_attr;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rr_tlb dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
    .rf_size(rf_size), .rf_attr(rf_attr), .inv_all(inv_all),
    .res_valid(res_valid), .res_hit(res_hit), .res_pa(res_pa),
    .res_attr(res_attr)
  );

  typedef struct packed {
    logic        is_look;
    logic [31:0] va;
    logic [31:0] pa;
    logic [1:0]  sz;
    logic [7:0]  attr;
    logic        hit;
    logic [31:0] epa;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b0, 32'h0040_3000, 32'h8001_2000, 2'd0, 8'h11, 1'b0, 32'h0, 4'd2},  // R2 fill
    '{1'b0, 32'h0051_0000, 32'h9034_0000, 2'd1, 8'h22, 1'b0, 32'h0, 4'd3},  // R3 fill
    '{1'b0, 32'h0120_0000, 32'hA300_0000, 2'd2, 8'h33, 1'b0, 32'h0, 4'd4},  // R4 fill
    '{1'b0, 32'h0067_8ABC, 32'h7123_4567, 2'd1, 8'h44, 1'b0, 32'h0, 4'd12}, // R12 fill
    '{1'b0, 32'h0ABF_F000, 32'hC12F_F000, 2'd2, 8'h55, 1'b0, 32'h0, 4'd12}, // R12 fill
    '{1'b1, 32'h0040_3ABC, 32'h0, 2'd0, 8'h11, 1'b1, 32'h8001_2ABC, 4'd2},  // R2
    '{1'b1, 32'h0040_4000, 32'h0, 2'd0, 8'h00, 1'b0, 32'h0, 4'd7},          // R7
    '{1'b1, 32'h0051_F123, 32'h0, 2'd0, 8'h22, 1'b1, 32'h9034_F123, 4'd3},  // R3
    '{1'b1, 32'h0052_0000, 32'h0, 2'd0, 8'h00, 1'b0, 32'h0, 4'd3},          // R3
    '{1'b1, 32'h012F_FFFC, 32'h0, 2'd0, 8'h33, 1'b1, 32'hA30F_FFFC, 4'd4},  // R4
    '{1'b1, 32'h0130_0000, 32'h0, 2'd0, 8'h00, 1'b0, 32'h0, 4'd4},          // R4
    '{1'b1, 32'h0067_0010, 32'h0, 2'd0, 8'h44, 1'b1, 32'h7123_0010, 4'd12}, // R12
    '{1'b1, 32'h0067_FFFF, 32'h0, 2'd0, 8'h44, 1'b1, 32'h7123_FFFF, 4'd12}, // R12
    '{1'b1, 32'h0AB1_2345, 32'h0, 2'd0, 8'h55, 1'b1, 32'hC121_2345, 4'd12}, // R12
    '{1'b1, 32'h0AA0_0000, 32'h0, 2'd0, 8'h00, 1'b0, 32'h0, 4'd7},          // R7
    '{1'b1, 32'h0040_3000, 32'h0, 2'd0, 8'h11, 1'b1, 32'h8001_2000, 4'd6}   // R6
  };

  task automatic chk(input logic ok, input string rq,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa,
                      input logic [1:0] sz, input logic [7:0] at);
    rf_valid = 1'b1; rf_vpn = va[31:12]; rf_pfn = pa[31:12];
    rf_size = sz; rf_attr = at;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic eh,
                      input logic [31:0] epa, input logic [7:0] eat,
                      input string rq);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid === 1'b1, {rq, " res_valid"}, 32'(res_valid), 32'd1);
    chk(res_hit === eh, {rq, " res_hit"}, 32'(res_hit), 32'(eh));
    if (eh) begin
      chk(res_pa === epa, {rq, " res_pa"}, res_pa, epa);
      chk(res_attr === eat, "R6 res_attr", 32'(res_attr), 32'(eat));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", n_chk);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs quiet in reset
    chk(res_valid === 1'b0, "R1 res_valid in reset", 32'(res_valid), 32'd0);
    chk(res_hit === 1'b0, "R1 res_hit in reset", 32'(res_hit), 32'd0);
    do_reset();
    chk(res_valid === 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'd0);
    look(32'h0040_3ABC, 1'b0, 32'h0, 8'h0, "R1 empty after reset");

    for (int i = 0; i < NV; i++) begin
      if (VT[i].is_look)
        look(VT[i].va, VT[i].hit, VT[i].epa, VT[i].attr, $sformatf("R%0d", VT[i].req));
      else
        fill(VT[i].va, VT[i].pa, VT[i].sz, VT[i].attr);
    end

    // R5: idle cycle gives no result
    @(negedge clk);
    chk(res_valid === 1'b0, "R5 idle", 32'(res_valid), 32'd0);

    // R9: invalidate everything
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    look(32'h0040_3ABC, 1'b0, 32'h0, 8'h0, "R9 small gone");
    look(32'h0051_F123, 1'b0, 32'h0, 8'h0, "R9 large gone");
    look(32'h012F_FFFC, 1'b0, 32'h0, 8'h0, "R9 seg gone");

    // R11: lookup with a simultaneous refill sees old contents
    rf_valid = 1'b1; rf_vpn = 20'h0ABCD; rf_pfn = 20'h55555;
    rf_size = 2'd0; rf_attr = 8'h66;
    lk_valid = 1'b1; lk_va = 32'h0ABC_D123;
    @(negedge clk);
    rf_valid = 1'b0; lk_valid = 1'b0;
    chk(res_valid === 1'b1, "R11 res_valid", 32'(res_valid), 32'd1);
    chk(res_hit === 1'b0, "R11 same-cycle miss", 32'(res_hit), 32'd0);
    look(32'h0ABC_D123, 1'b1, 32'h5555_5123, 8'h66, "R11 visible next");

    // R8 and R10: round-robin order from a fresh reset
    do_reset();
    inv_all = 1'b1; rf_valid = 1'b1; rf_vpn = 20'h30000; rf_pfn = 20'h40000;
    rf_size = 2'd0; rf_attr = 8'h77;
    @(negedge clk);
    inv_all = 1'b0; rf_valid = 1'b0;
    look(32'h3000_0000, 1'b0, 32'h0, 8'h0, "R10 refill dropped");
    for (int i = 0; i < 32; i++)
      fill(32'h1000_0000 + (i << 12), 32'h2000_0000 + (i << 12), 2'd0, 8'(i));
    look(32'h1000_0004, 1'b1, 32'h2000_0004, 8'd0, "R8 entry 0 present");
    look(32'h1001_F008, 1'b1, 32'h2001_F008, 8'd31, "R8 entry 31 present");
    fill(32'h1010_0000, 32'h2010_0000, 2'd0, 8'hA0);
    look(32'h1000_0000, 1'b0, 32'h0, 8'h0, "R10 R8 first mapping evicted");
    look(32'h1000_1000, 1'b1, 32'h2000_1000, 8'd1, "R8 second survives");
    look(32'h1010_0ABC, 1'b1, 32'h2010_0ABC, 8'hA0, "R8 new mapping");
    fill(32'h1020_0000, 32'h2020_0000, 2'd0, 8'hA1);
    look(32'h1000_1000, 1'b0, 32'h0, 8'h0, "R8 second evicted next");
    look(32'h1000_2000, 1'b1, 32'h2000_2000, 8'd2, "R8 third survives");

    finish_run();
  end
endmodule